// File: doc/BRIEF.md
# Receive Pause Frame Detector and Pause Timer

This block watches the byte stream a full-duplex Ethernet MAC receives and picks out valid PAUSE control frames. When one is accepted, it loads a countdown with the frame's pause time. A transmit-pause signal stays high while that countdown is non-zero, so the local transmitter can hold off between frames. The countdown drops by one on each quantum tick. Each tick stands for 64 byte times at any line rate.

Each received byte arrives with a valid strobe. The first byte carries a start marker and the last byte carries an end marker together with a CRC-good flag. One cycle after the end byte, the block pulses a control-frame-detected flag. In that same cycle it gives a pass-to-application verdict: control frames go up only when the pass-control setting allows it, and every other frame is always passed. CRC computation and general address filtering are done elsewhere.

Top module: `pause_rx_ctrl`

## Requirements
- R1: When `fc_rx_en` is 0 or `full_duplex` is 0 at the end byte, the frame is neither detected nor loaded, and `pass_to_app` is 1.
- R2: The destination address is bytes 0..5, with the first byte on the wire as the most significant. A frame is a candidate when the address equals 01-80-C2-00-00-01 or equals `station_addr`, where `station_addr[47:40]` is byte 0. Any other address gives no detection.
- R3: `ctrl_detect` pulses for one cycle, one cycle after the end byte, when the block is enabled, the frame is a candidate, the frame is at least 18 bytes long, and bytes 12..13 are 0x88, 0x08.
- R4: The timer is loaded only for a detected frame whose bytes 14..15 are 0x00, 0x01, whose length counted from the start byte through the end byte is exactly 64, and whose CRC-good flag is 1. Any other frame leaves the timer unchanged.
- R5: The pause time is bytes 16 (high byte) and 17 (low byte). `tx_pause` is high from the cycle after the end byte for as long as the counter is non-zero. The counter drops by one on each `quanta_tick`.
- R6: A valid pause frame that arrives while a pause is running reloads the counter with its own time. A time of zero makes `tx_pause` low in the cycle after the end byte.
- R7: `pass_to_app` pulses in the cycle after every end byte. It equals `pass_ctrl_cfg` when the frame is detected and is 1 otherwise. It is 0 in every other cycle.
- R8: After reset, `tx_pause`, `ctrl_detect` and `pass_to_app` are all 0, and `quanta_tick` on its own leaves `tx_pause` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_crc_ok | input | 1 | CRC good, sampled with the end byte |
| fc_rx_en | input | 1 | Receive flow-control enable |
| full_duplex | input | 1 | Link is in full-duplex mode |
| pass_ctrl_cfg | input | 1 | Forward detected control frames to the application |
| station_addr | input | 48 | Local unicast address, first byte in bits 47:40 |
| quanta_tick | input | 1 | One pulse per 64 byte times |
| tx_pause | output | 1 | Hold off the transmitter |
| ctrl_detect | output | 1 | Control frame detected (one-cycle pulse) |
| pass_to_app | output | 1 | Forwarding verdict for the frame that just ended (one-cycle pulse) |

## Verification
The bench builds the block with its default values: a 16-bit pause time, an 8-bit saturating byte counter and a 64-byte control frame length. With these values, frames of 63, 64 and 65 bytes cover both sides of the exact-length rule. Pause times of 2, 3, 5 and 9 make countdowns short enough to step through tick by tick. Loading a time of 3 and reaching zero after three ticks would fail if the two pause-time bytes were swapped, because the swapped value would be 0x0300.

// File: rtl/pause_pkg.sv
// Package: shared constants and the per-frame verdict type for the pause
// frame detector. Assumes standard MAC control framing, counted from the
// first destination address byte.
package pause_pkg;
    localparam logic [47:0] MAC_CTRL_DA    = 48'h0180_C200_0001;
    localparam logic [15:0] CTRL_ETHERTYPE = 16'h8808;
    localparam logic [15:0] OPC_PAUSE      = 16'h0001;
    localparam int          ADDR_BYTES     = 6;
    localparam int          OFS_TYPE       = 12;
    localparam int          OFS_OPCODE     = 14;
    localparam int          OFS_PTIME      = 16;
    localparam int          HDR_LAST       = 17;

    typedef struct packed {
        logic detect;
        logic load;
    } frame_verdict_t;
endpackage

// File: rtl/pause_da_match.sv
// Module: compares the destination address bytes of a frame with the MAC
// control multicast address and with the station unicast address.
// Assumes the caller supplies the byte index (0 on the start byte). The
// hit output is final once all address bytes have gone by.
module pause_da_match
    import pause_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_en,
    input  logic [7:0]       byte_in,
    input  logic [LEN_W-1:0] byte_idx,
    input  logic [47:0]      station_addr,
    output logic             da_hit
);
    localparam int SEL_W = $clog2(ADDR_BYTES);

    logic [7:0] mc_exp [ADDR_BYTES];
    logic [7:0] uc_exp [ADDR_BYTES];
    logic       mc_ok, uc_ok;
    logic       in_da;
    logic [SEL_W-1:0] sel;

    // Split both reference addresses into bytes, first wire byte at index 0.
    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_addr_bytes
        assign mc_exp[k] = MAC_CTRL_DA[8*(ADDR_BYTES-1-k) +: 8];
        assign uc_exp[k] = station_addr[8*(ADDR_BYTES-1-k) +: 8];
    end

    // Decide whether the current byte lies in the address field.
    always_comb begin
        in_da = (byte_idx < LEN_W'(ADDR_BYTES));
        sel   = SEL_W'(byte_idx);
    end

    // Running match flags, restarted on address byte 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_ok <= 1'b0;
            uc_ok <= 1'b0;
        end else if (byte_en && in_da) begin
            if (byte_idx == '0) begin
                mc_ok <= (byte_in == mc_exp[sel]);
                uc_ok <= (byte_in == uc_exp[sel]);
            end else begin
                mc_ok <= mc_ok && (byte_in == mc_exp[sel]);
                uc_ok <= uc_ok && (byte_in == uc_exp[sel]);
            end
        end
    end

    assign da_hit = mc_ok || uc_ok;
endmodule

// File: rtl/pause_frame_parser.sv
// Module: counts the bytes of each frame, captures the type, opcode and
// pause-time fields, and at the end byte decides whether the frame is a
// detected control frame and whether it carries a valid pause. The load
// request and value are combinational in the end-byte cycle. The detect and
// pass flags are registered pulses one cycle later. Assumes that rx_sof and
// rx_eof are only meaningful while rx_valid is high.
module pause_frame_parser
    import pause_pkg::*;
#(
    parameter int LEN_W    = 8,
    parameter int PTIME_W  = 16,
    parameter int CTRL_LEN = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    input  logic               rx_sof,
    input  logic               rx_eof,
    input  logic               rx_crc_ok,
    input  logic               fc_rx_en,
    input  logic               full_duplex,
    input  logic               pass_ctrl_cfg,
    input  logic [47:0]        station_addr,
    output logic               pause_load,
    output logic [PTIME_W-1:0] pause_val,
    output logic               ctrl_detect,
    output logic               pass_to_app
);
    localparam logic [LEN_W-1:0] CNT_MAX  = '1;
    localparam logic [LEN_W-1:0] LEN_LAST = LEN_W'(CTRL_LEN - 1);

    logic [LEN_W-1:0] byte_cnt, cur_idx;
    logic [15:0]      type_r, opc_r;
    logic [15:0]      ptime_hi_lo;
    logic             da_hit;
    logic             frame_end, enabled, hdr_ok, len_ok;
    frame_verdict_t   verdict;

    // Index of the byte on the bus: a start marker forces index 0.
    always_comb cur_idx = rx_sof ? '0 : byte_cnt;

    // Saturating byte counter that points at the next byte of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            byte_cnt <= '0;
        else if (rx_valid)
            byte_cnt <= (cur_idx == CNT_MAX) ? CNT_MAX : cur_idx + 1'b1;
    end

    // Capture the two-byte fields that follow the addresses, high byte first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_r      <= '0;
            opc_r       <= '0;
            ptime_hi_lo <= '0;
        end else if (rx_valid) begin
            case (cur_idx)
                LEN_W'(OFS_TYPE):       type_r[15:8]      <= rx_data;
                LEN_W'(OFS_TYPE + 1):   type_r[7:0]       <= rx_data;
                LEN_W'(OFS_OPCODE):     opc_r[15:8]       <= rx_data;
                LEN_W'(OFS_OPCODE + 1): opc_r[7:0]        <= rx_data;
                LEN_W'(OFS_PTIME):      ptime_hi_lo[15:8] <= rx_data;
                LEN_W'(OFS_PTIME + 1):  ptime_hi_lo[7:0]  <= rx_data;
                default: ;
            endcase
        end
    end

    pause_da_match #(.LEN_W(LEN_W)) u_da (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_en      (rx_valid),
        .byte_in      (rx_data),
        .byte_idx     (cur_idx),
        .station_addr (station_addr),
        .da_hit       (da_hit)
    );

    // Evaluate the verdict for the frame whose end byte is on the bus.
    always_comb begin
        frame_end      = rx_valid && rx_eof;
        enabled        = fc_rx_en && full_duplex;
        hdr_ok         = (cur_idx >= LEN_W'(HDR_LAST));
        len_ok         = (cur_idx == LEN_LAST);
        verdict.detect = frame_end && enabled && hdr_ok && da_hit &&
                         (type_r == CTRL_ETHERTYPE);
        verdict.load   = verdict.detect && (opc_r == OPC_PAUSE) &&
                         len_ok && rx_crc_ok;
    end

    assign pause_load = verdict.load;
    assign pause_val  = PTIME_W'(ptime_hi_lo);

    // Registered per-frame pulses: detection and the forwarding verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_detect <= 1'b0;
            pass_to_app <= 1'b0;
        end else begin
            ctrl_detect <= verdict.detect;
            pass_to_app <= frame_end && (!verdict.detect || pass_ctrl_cfg);
        end
    end

    // R1: with flow control or full duplex off, a frame end gives no detection and is passed.
    a_r1_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_eof && !(fc_rx_en && full_duplex)) |=> (!ctrl_detect && pass_to_app));

    // R3: detection only ever follows an end byte.
    a_r3_detect_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_detect |-> $past(rx_valid && rx_eof));

    // R7: the forwarding pulse only ever follows an end byte.
    a_r7_pass_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        pass_to_app |-> $past(rx_valid && rx_eof));
endmodule

// File: rtl/pause_quanta_timer.sv
// Module: pause countdown in units of pause quanta. A load sets the count
// (a zero load cancels the pause). Otherwise each quantum tick takes one
// off a non-zero count. Assumes the tick is a single-cycle pulse.
module pause_quanta_timer #(
    parameter int PTIME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PTIME_W-1:0] load_val,
    input  logic               tick,
    output logic               pause_active
);
    logic [PTIME_W-1:0] count;

    // Countdown register: a load takes priority over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (tick && (count != '0))
            count <= count - 1'b1;
    end

    assign pause_active = (count != '0);

    // R5: a tick with no load takes exactly one off a running count.
    a_r5_tick_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && pause_active) |=> (count == $past(count) - 1'b1));

    // R5: with neither load nor tick the count holds.
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(count));

    // R6: a zero-time load ends the pause in the next cycle.
    a_r6_zero_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (load_val == '0)) |=> !pause_active);
endmodule

// File: rtl/pause_rx_ctrl.sv
// Module (top): receive-side PAUSE frame detector with a pause countdown
// for the transmitter. Assumes a full-duplex MAC that supplies the byte
// stream with start and end markers, a CRC-good flag at the end byte and a
// quantum tick every 64 byte times.
module pause_rx_ctrl #(
    parameter int PTIME_W  = 16,
    parameter int LEN_W    = 8,
    parameter int CTRL_LEN = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        rx_crc_ok,
    input  logic        fc_rx_en,
    input  logic        full_duplex,
    input  logic        pass_ctrl_cfg,
    input  logic [47:0] station_addr,
    input  logic        quanta_tick,
    output logic        tx_pause,
    output logic        ctrl_detect,
    output logic        pass_to_app
);
    logic               pause_load;
    logic [PTIME_W-1:0] pause_val;

    pause_frame_parser #(
        .LEN_W    (LEN_W),
        .PTIME_W  (PTIME_W),
        .CTRL_LEN (CTRL_LEN)
    ) u_parser (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .rx_sof        (rx_sof),
        .rx_eof        (rx_eof),
        .rx_crc_ok     (rx_crc_ok),
        .fc_rx_en      (fc_rx_en),
        .full_duplex   (full_duplex),
        .pass_ctrl_cfg (pass_ctrl_cfg),
        .station_addr  (station_addr),
        .pause_load    (pause_load),
        .pause_val     (pause_val),
        .ctrl_detect   (ctrl_detect),
        .pass_to_app   (pass_to_app)
    );

    pause_quanta_timer #(.PTIME_W(PTIME_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (pause_load),
        .load_val     (pause_val),
        .tick         (quanta_tick),
        .pause_active (tx_pause)
    );

    // R4: a timer load is always accompanied by a detected control frame.
    a_r4_load_needs_detect: assert property (@(posedge clk) disable iff (!rst_n)
        pause_load |=> ctrl_detect);

    // R5: a non-zero load raises the transmit pause in the next cycle.
    a_r5_load_raises_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_load && (pause_val != '0)) |=> tx_pause);
endmodule

// File: tb/pause_rx_ctrl_tb.sv
// Bench: walks a vector table of single frames, resetting before each one,
// then runs directed countdown, reload, cancel and reset tests.
module pause_rx_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid, rx_sof, rx_eof, rx_crc_ok;
    logic [7:0]  rx_data;
    logic        fc_rx_en, full_duplex, pass_ctrl_cfg, quanta_tick;
    logic [47:0] station_addr;
    logic        tx_pause, ctrl_detect, pass_to_app;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    localparam logic [47:0] MC_DA    = 48'h0180_C200_0001;
    localparam logic [47:0] ST_DA    = 48'h02AB_CDEF_1234;
    localparam logic [47:0] OTHER_DA = 48'h0180_C200_0002;

    always #10 clk = ~clk;

    pause_rx_ctrl dut_i (
        .clk (clk), .rst_n (rst_n), .rx_valid (rx_valid), .rx_data (rx_data),
        .rx_sof (rx_sof), .rx_eof (rx_eof), .rx_crc_ok (rx_crc_ok),
        .fc_rx_en (fc_rx_en), .full_duplex (full_duplex),
        .pass_ctrl_cfg (pass_ctrl_cfg), .station_addr (station_addr),
        .quanta_tick (quanta_tick), .tx_pause (tx_pause),
        .ctrl_detect (ctrl_detect), .pass_to_app (pass_to_app)
    );

    typedef struct packed {
        logic [1:0]  da_sel;   // 0 control multicast, 1 station, 2 other
        logic [15:0] ty;
        logic [15:0] op;
        logic [15:0] pt;
        logic [7:0]  len;
        logic        crc;
        logic        en;
        logic        fd;
        logic        pcf;
        logic        exp_det;
        logic        exp_pass;
        logic        exp_pause;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'h8808, 16'h0001, 16'd5, 8'd64, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R3 R4 R7
        '{2'd0, 16'h8808, 16'h0001, 16'd5, 8'd64, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R7 pass
        '{2'd1, 16'h8808, 16'h0001, 16'd5, 8'd64, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R2 station
        '{2'd2, 16'h8808, 16'h0001, 16'd5, 8'd64, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 other DA
        '{2'd0, 16'h0800, 16'h0001, 16'd5, 8'd64, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 type
        '{2'd0, 16'h8808, 16'h0002, 16'd5, 8'd64, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 opcode
        '{2'd0, 16'h8808, 16'h0001, 16'd5, 8'd65, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 long
        '{2'd0, 16'h8808, 16'h0001, 16'd5, 8'd63, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 short
        '{2'd0, 16'h8808, 16'h0001, 16'd5, 8'd64, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 crc
        '{2'd0, 16'h8808, 16'h0001, 16'd5, 8'd64, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R1 enable
        '{2'd0, 16'h8808, 16'h0001, 16'd5, 8'd64, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R1 duplex
        '{2'd0, 16'h8808, 16'h0001, 16'd0, 8'd64, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}  // R6 zero time
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] frame_byte(input int i, input logic [47:0] da,
                                              input logic [15:0] ty, op, pt);
        if (i < 6)       return da[47-8*i -: 8];
        else if (i < 12) return 8'(8'h20 + i);
        else if (i == 12) return ty[15:8];
        else if (i == 13) return ty[7:0];
        else if (i == 14) return op[15:8];
        else if (i == 15) return op[7:0];
        else if (i == 16) return pt[15:8];
        else if (i == 17) return pt[7:0];
        else             return 8'(i);
    endfunction

    // Sends one frame; returns at the negedge after the end byte was clocked.
    task automatic send_frame(input logic [47:0] da, input logic [15:0] ty, op, pt,
                              input int len, input logic crc);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid  = 1'b1;
            rx_sof    = (i == 0);
            rx_eof    = (i == len - 1);
            rx_crc_ok = (i == len - 1) ? crc : 1'b0;
            rx_data   = frame_byte(i, da, ty, op, pt);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_ok = 1'b0;
    endtask

    task automatic tick_once();
        @(negedge clk); quanta_tick = 1'b1;
        @(negedge clk); quanta_tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_crc_ok = 0;
        rx_data = 0; fc_rx_en = 1; full_duplex = 1; pass_ctrl_cfg = 0;
        quanta_tick = 0; station_addr = ST_DA;
        do_reset();
        @(negedge clk);
        check("R8 reset tx_pause", tx_pause, 1'b0);
        check("R8 reset ctrl_detect", ctrl_detect, 1'b0);
        check("R8 reset pass_to_app", pass_to_app, 1'b0);
        tick_once();
        check("R8 idle tick tx_pause", tx_pause, 1'b0);

        for (int v = 0; v < NV; v++) begin
            logic [47:0] da;
            do_reset();
            fc_rx_en = VECS[v].en; full_duplex = VECS[v].fd;
            pass_ctrl_cfg = VECS[v].pcf;
            da = (VECS[v].da_sel == 2'd0) ? MC_DA :
                 (VECS[v].da_sel == 2'd1) ? ST_DA : OTHER_DA;
            send_frame(da, VECS[v].ty, VECS[v].op, VECS[v].pt,
                       int'(VECS[v].len), VECS[v].crc);
            check($sformatf("R3 vec%0d ctrl_detect", v), ctrl_detect, VECS[v].exp_det);
            check($sformatf("R7 vec%0d pass_to_app", v), pass_to_app, VECS[v].exp_pass);
            check($sformatf("R4 vec%0d tx_pause", v), tx_pause, VECS[v].exp_pause);
            @(negedge clk);
            check($sformatf("R7 vec%0d pass pulse ends", v), pass_to_app, 1'b0);
        end

        fc_rx_en = 1; full_duplex = 1; pass_ctrl_cfg = 0;

        // R5: time 3 counts down over three ticks (swapped bytes would give 0x0300).
        do_reset();
        send_frame(MC_DA, 16'h8808, 16'h0001, 16'd3, 64, 1'b1);
        check("R5 pause after load", tx_pause, 1'b1);
        tick_once(); tick_once();
        check("R5 pause after 2 ticks", tx_pause, 1'b1);
        tick_once();
        check("R5 pause ends after 3 ticks", tx_pause, 1'b0);

        // R6: reload while running.
        do_reset();
        send_frame(MC_DA, 16'h8808, 16'h0001, 16'd5, 64, 1'b1);
        tick_once();
        send_frame(MC_DA, 16'h8808, 16'h0001, 16'd2, 64, 1'b1);
        tick_once();
        check("R6 reload still paused", tx_pause, 1'b1);
        tick_once();
        check("R6 reload ends after new time", tx_pause, 1'b0);

        // R6: zero time cancels a running pause at once.
        do_reset();
        send_frame(ST_DA, 16'h8808, 16'h0001, 16'd9, 64, 1'b1);
        check("R6 paused before cancel", tx_pause, 1'b1);
        send_frame(MC_DA, 16'h8808, 16'h0001, 16'd0, 64, 1'b1);
        check("R6 zero time cancels", tx_pause, 1'b0);

        // R4: a bad-CRC pause frame leaves a running pause unchanged.
        do_reset();
        send_frame(MC_DA, 16'h8808, 16'h0001, 16'd2, 64, 1'b1);
        send_frame(MC_DA, 16'h8808, 16'h0001, 16'd0, 64, 1'b0);
        check("R4 bad crc keeps pause", tx_pause, 1'b1);
        tick_once(); tick_once();
        check("R4 original countdown ends", tx_pause, 1'b0);

        // R1: disabling flow control mid-pause does not cancel via a zero frame.
        do_reset();
        send_frame(MC_DA, 16'h8808, 16'h0001, 16'd4, 64, 1'b1);
        fc_rx_en = 0;
        send_frame(MC_DA, 16'h8808, 16'h0001, 16'd0, 64, 1'b1);
        check("R1 disabled zero frame ignored", tx_pause, 1'b1);
        fc_rx_en = 1;

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule